// File: doc/BRIEF.md
# Soft-Switch ROM Bank Selector

This block sits on the system bus of an 8-bit microcomputer with a 16-bit address space. It decodes processor accesses into the upper ROM region and into a small group of soft-switch addresses in the I/O page. Four switch addresses control a 2-bit bank register. Each bank bit has its own clear address and its own set address. A switch acts on any access to its address, whether a read or a write. The register chooses one of four 12 KiB banks in a 48 KiB physical ROM.

A processor read anywhere in 0xD000..0xFFFF drives the ROM address lines in the same cycle. The address is formed from the bank in effect at that moment and the offset into the region. The external synchronous ROM returns its byte one clock later, and the block forwards that byte with a valid flag. A read of a bank switch returns 0x00 through the same path. Writes into the ROM region do nothing. The two write-only display switches, and every access the block does not decode, also do nothing.

Top module: `romBankSel`

## Requirements
- R1: An access with busValid high, read or write, to 0xC058 clears bank bit 0, and an access to 0xC059 sets it. Bank bit 1 keeps its value in both cases.
- R2: An access, read or write, to 0xC05A clears bank bit 1, and an access to 0xC05B sets it. Bank bit 0 keeps its value in both cases.
- R3: After reset the bank register holds 0, and rdValid and romRdEn are low.
- R4: For a read at CPU address A in 0xD000..0xFFFF, romRdEn is high in the same cycle and romAddr equals bank*12288 + (A - 0xD000). romAddr therefore never exceeds 49151.
- R5: A ROM-region read raises rdValid one clock later. In that cycle rdData equals romData, the byte the synchronous ROM returns for the address presented at that edge.
- R6: A read of any of 0xC058..0xC05B raises rdValid one clock later, with rdData = 0x00.
- R7: A write into 0xD000..0xFFFF leaves romRdEn low, gives no rdValid, and leaves the bank register unchanged.
- R8: Writes to 0xC00C and 0xC00E, and accesses to any other address outside the ROM region and the four switches, leave the bank unchanged and never raise rdValid.
- R9: A ROM read uses the bank held at the start of its access. A switch access changes the bank from the very next access on, even when that access follows back to back.
- R10: Only addresses 0xC000..0xC0FF count as the I/O page. An address such as 0xC158 or 0xC259 with a switch's low byte has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the access strobe is sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | One-cycle access strobe |
| busWrite | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 16 | CPU address of the access |
| romAddr | output | 16 | Physical ROM byte address (0..49151) |
| romRdEn | output | 1 | ROM read request in this cycle |
| romData | input | 8 | Byte from the synchronous ROM, one clock after the request |
| rdValid | output | 1 | Read data returned in this cycle |
| rdData | output | 8 | Returned read byte |

## Verification
The hardest case to reach is a switch access followed directly by a ROM read in the next cycle. That read must see the new bank, while the switch access itself, or a ROM read in the same cycle as an update, must see the old one. The bench drives accesses back to back with no idle cycle between them. It walks the register through all four banks, mixing read and write switch accesses. After each bank change it sweeps the whole ROM region with a prime stride. Writes into the ROM region, the display switch writes and aliased page addresses are mixed into each sweep. Their lack of effect then shows up in the bytes read straight afterwards.

// File: rtl/romBankPkg.sv
package romBankPkg;
  localparam int ADDR_W        = 16;
  localparam int DATA_W        = 8;
  localparam int BANK_BITS     = 2;
  localparam int NUM_BANKS     = 1 << BANK_BITS;
  localparam int WIN_BYTES     = 2048;
  localparam int WINS_PER_BANK = 6;
  localparam int BANK_BYTES    = WIN_BYTES * WINS_PER_BANK;
  localparam int ROM_BYTES     = NUM_BANKS * BANK_BYTES;
  localparam int ROM_AW        = $clog2(ROM_BYTES);

  localparam logic [ADDR_W-1:0] ROM_BASE = 16'hD000;
  localparam logic [7:0]        IO_PAGE  = 8'hC0;
  localparam logic [7:0]        SW_BASE  = 8'h58;

  typedef struct packed {
    logic                 romRead;
    logic                 swRead;
    logic [BANK_BITS-1:0] clrBit;
    logic [BANK_BITS-1:0] setBit;
  } bankStrobes_t;
endpackage

// File: rtl/romBankCtrl.sv
module romBankCtrl
  import romBankPkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output bankStrobes_t      strb
);
  logic ioHit;
  logic romHit;
  logic [BANK_BITS-1:0] clrHit;
  logic [BANK_BITS-1:0] setHit;

  assign ioHit  = busValid && (busAddr[ADDR_W-1:8] == IO_PAGE);
  assign romHit = busAddr >= ROM_BASE;

  // Bit i is cleared at SW_BASE+2i and set at SW_BASE+2i+1.
  // The display switches at 0x0C/0x0E fall through here and change nothing.
  for (genvar i = 0; i < BANK_BITS; i++) begin : g_sw
    localparam logic [7:0] CLR_OFF = SW_BASE + 8'(2 * i);
    localparam logic [7:0] SET_OFF = SW_BASE + 8'(2 * i + 1);
    assign clrHit[i] = ioHit && (busAddr[7:0] == CLR_OFF);
    assign setHit[i] = ioHit && (busAddr[7:0] == SET_OFF);
  end

  always_comb begin
    strb.clrBit  = clrHit;
    strb.setBit  = setHit;
    strb.swRead  = !busWrite && ((|clrHit) || (|setHit));
    strb.romRead = busValid && !busWrite && romHit;
  end
endmodule

// File: rtl/romBankDp.sv
module romBankDp
  import romBankPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strb,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romRdEn,
  input  logic [DATA_W-1:0] romData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [BANK_BITS-1:0] bankQ;
  logic                 rdIsSwQ;
  logic [ROM_AW-1:0]    bankBase;
  logic [ROM_AW-1:0]    regionOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= '0;
    end else begin
      for (int i = 0; i < BANK_BITS; i++) begin
        if (strb.clrBit[i])      bankQ[i] <= 1'b0;
        else if (strb.setBit[i]) bankQ[i] <= 1'b1;
      end
    end
  end

  // The address is formed from the bank value before this edge's update.
  assign bankBase  = ROM_AW'(bankQ) * ROM_AW'(BANK_BYTES);
  assign regionOff = ROM_AW'(busAddr - ROM_BASE);
  assign romAddr   = strb.romRead ? (bankBase + regionOff) : '0;
  assign romRdEn   = strb.romRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdIsSwQ <= 1'b0;
    end else begin
      rdValid <= strb.romRead || strb.swRead;
      rdIsSwQ <= strb.swRead;
    end
  end

  assign rdData = rdIsSwQ ? '0 : romData;

  for (genvar i = 0; i < BANK_BITS; i++) begin : g_chk
    // R1 / R2: each switch moves only its own bit.
    assert_bit_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrBit[i] |=> (bankQ[i] == 1'b0));
    assert_bit_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.setBit[i] && !strb.clrBit[i]) |=> (bankQ[i] == 1'b1));
    assert_bit_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.setBit[i] && !strb.clrBit[i]) |=> $stable(bankQ[i]));
  end

  assert_switch_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.swRead) |-> (rdValid && rdData == '0));
  assert_valid_has_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.romRead || strb.swRead));
endmodule

// File: rtl/romBankSel.sv
module romBankSel
  import romBankPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [15:0] busAddr,
  output logic [15:0] romAddr,
  output logic        romRdEn,
  input  logic [7:0]  romData,
  output logic        rdValid,
  output logic [7:0]  rdData
);
  bankStrobes_t strb;

  romBankCtrl u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  romBankDp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busAddr  (busAddr),
    .romAddr  (romAddr),
    .romRdEn  (romRdEn),
    .romData  (romData),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  assert_rom_read_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    romRdEn |-> (busValid && !busWrite && busAddr >= ROM_BASE));
  assert_rom_addr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    romRdEn |-> (int'(romAddr) < ROM_BYTES));
endmodule

// File: tb/romBankSel_tb.sv
module romBankSel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [15:0] romAddr;
  logic        romRdEn;
  logic [7:0]  romData = '0;
  logic        rdValid;
  logic [7:0]  rdData;

  int vectors = 0;
  int errors  = 0;
  int model   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  romBankSel u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .romAddr(romAddr), .romRdEn(romRdEn),
    .romData(romData), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic [7:0] romByte(input int a);
    return 8'(a) ^ 8'((a >> 8) * 37);
  endfunction

  // Synchronous ROM model, contents computed from the address.
  always @(posedge clk) romData <= romByte(int'(romAddr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; leaves the strobe at the next falling edge.
  task automatic access(input int a, input bit wr);
    bit inRom, isSw, expValid;
    int expAddr, expData;
    inRom = a >= 'hD000;
    isSw  = (a >= 'hC058) && (a <= 'hC05B);
    expAddr = model * 12288 + (a - 'hD000);
    busValid = 1'b1; busWrite = wr; busAddr = 16'(a);
    #1;
    if (inRom && !wr) chk(romRdEn && romAddr == 16'(expAddr), "R4 romAddr", int'(romAddr), expAddr);
    else              chk(!romRdEn, "R7 romRdEn", int'(romRdEn), 0);
    @(negedge clk);
    busValid = 1'b0;
    expValid = !wr && (inRom || isSw);
    expData  = isSw ? 0 : int'(romByte(expAddr));
    chk(rdValid == expValid, isSw ? "R6 rdValid" : (inRom ? "R5 rdValid" : "R8 rdValid"),
        int'(rdValid), int'(expValid));
    if (expValid)
      chk(rdData == 8'(expData), isSw ? "R6 rdData" : "R5/R9 rdData", int'(rdData), expData);
    if (isSw) begin
      if (a == 'hC058) model = model & 2;
      if (a == 'hC059) model = model | 1;
      if (a == 'hC05A) model = model & 1;
      if (a == 'hC05B) model = model | 2;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdValid && !romRdEn, "R3 outputs in reset", int'(rdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    access('hD000, 0);                       // R3: bank 0 after reset
    access('hFFFF, 0);
    for (int b = 0; b < 4; b++) begin
      bit useWr = b[0];
      // R1 / R2 driven by reads or writes; back to back with next read (R9).
      access((b & 1) ? 'hC059 : 'hC058, useWr);
      access((b & 2) ? 'hC05B : 'hC05A, !useWr);
      chk(model == b, "R1/R2 model", model, b);
      access('hD000, 0);
      for (int a = 'hD000; a <= 'hFFFF; a += 7) begin
        access(a, 0);
        if (((a - 'hD000) % 448) == 0) begin
          access('hE000 + (a & 'hFFF), 1);   // R7
          access('hC00C, 1);                 // R8
          access('hC00E, 1);                 // R8
          access('hB000 + (a & 'hFF), 0);    // R8
          access('hC158 + (b & 3), 0);       // R10
          access('hC259 + (b & 2), 1);       // R10
          access('hC05C, 0);                 // R8
          access(a, 0);
        end
      end
      access('hFFFF, 0);
      access('hF800, 0);
    end
    // R9: bit toggles one at a time, each followed at once by a read.
    access('hC058, 1); access('hD7FF, 0);
    access('hC05A, 0); access('hE801, 0);
    access('hC05B, 0); access('hD000, 0);
    access('hC059, 1); access('hFFFE, 0);
    access('hC058, 0); access('hC05A, 1); access('hF123, 0);
    chk(model == 0, "R1/R2 final", model, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule